// File: doc/BRIEF.md
# IP Header Checksum Checker

This block watches the bytes of a received Ethernet frame as they stream past, beginning with the destination address. A start marker and an end marker delimit each frame. The block reads the EtherType, skipping one VLAN tag if there is one, and sorts the frame into IPv4, IPv6 or any other kind. For IPv4 it also checks the header as the bytes arrive. It adds the header up as 16-bit words in one's-complement arithmetic, over the length that the header-length nibble gives, and confirms that the stored checksum makes the total come out right.

One cycle after the last byte of a frame, the block gives a one-cycle result strobe. The strobe carries a type flag for each kind of frame and a header-error flag. An enable input switches checking on or off. The block holds no frame data, so it sits beside a receive path without stalling it.

Top module: `ipcsum_checker`

## Requirements
- R1: The result outputs `outValid`, `isIpv4`, `isIpv6` and `hdrErr` go high only in the one cycle that follows the clock edge that accepts a byte with `inEof` set. The three flags are 0 whenever `outValid` is 0, and all four are 0 after reset.
- R2: The 16-bit type is read big-endian from frame byte offsets 12 and 13, where byte 0 is the one marked by `inSof`. Type 0x0800 gives `isIpv4`, type 0x86DD gives `isIpv6`, and any other type gives neither flag. The two flags are never high together.
- R3: When the type at offsets 12/13 is 0x8100, the type is read again at offsets 16/17. Only one tag is skipped, so a second 0x8100 classifies the frame as other.
- R4: The IPv4 header starts right after the type field. Its bytes are paired into 16-bit words, with the earlier byte high, and summed with end-around carry. The header is valid only if the total is 0xFFFF; any other total sets `hdrErr`.
- R5: The first header byte holds the version in bits 7:4 and IHL in bits 3:0. The header spans IHL×4 bytes, options included, and bytes after that span do not change the result.
- R6: An IHL below 5 sets `hdrErr`.
- R7: A version field other than 4 after type 0x0800 sets `hdrErr`.
- R8: An IPv4 frame that ends before its last header byte sets `hdrErr`. A frame whose final byte is the last header byte is judged on its complete header.
- R9: `enable` is sampled with the `inSof` byte. When it is 0, the frame still yields `outValid` but all three flags stay 0. Changing `enable` after the start byte has no effect on that frame.
- R10: `hdrErr` is set only together with `isIpv4`.
- R11: A byte is accepted only when `inValid` is 1, so idle cycles inside a frame have no effect. Bytes between an end marker and the next start marker are ignored. An `inSof` in the middle of a frame abandons the old frame and starts a new one at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Checking enable, sampled with the start byte |
| inValid | input | 1 | A byte is present this cycle |
| inData | input | 8 | Frame byte |
| inSof | input | 1 | This byte is frame byte 0 |
| inEof | input | 1 | This byte is the last of the frame |
| outValid | output | 1 | Result strobe for the frame that just ended |
| isIpv4 | output | 1 | Frame classified IPv4 |
| isIpv6 | output | 1 | Frame classified IPv6 |
| hdrErr | output | 1 | IPv4 header failed a check |

## Verification
The end-of-frame result can be due in the same cycle that the last header byte completes the checksum sum, or the same cycle that the second type byte settles the class. In both cases the result has to use this cycle's update and not the registered state. The bench provokes this by cutting a valid IPv4 frame so that its final byte is the final header byte, which must report a clean IPv4 header. It also cuts a frame right after the type field and one byte before the header end, and both of those must report a header error. For each case the bench compares the flags sampled in the cycle after the end byte with values it works out from the frame contents.

// File: rtl/ipcsum_pkg.sv
package ipcsum_pkg;

  localparam logic [15:0] TYPE_IPV4 = 16'h0800;
  localparam logic [15:0] TYPE_IPV6 = 16'h86DD;
  localparam logic [15:0] TYPE_VLAN = 16'h8100;
  localparam int          VLAN_LEN  = 4;
  localparam int          MIN_IHL   = 5;
  localparam int          HDR_POS_W = 6;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_V4    = 2'd1,
    KIND_V6    = 2'd2,
    KIND_OTHER = 2'd3
  } frameKind_t;

  typedef struct packed {
    logic clrSum;
    logic latchType;
    logic latchHi;
    logic addWord;
  } dpStrobe_t;

endpackage

// File: rtl/ipcsum_datapath.sv
module ipcsum_datapath
  import ipcsum_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strobe,
  input  logic [7:0]  inData,
  output logic [15:0] etherType,
  output logic        wordAllOnes
);

  logic [7:0]  typeHi;
  logic [7:0]  hiByte;
  logic        hiPending;
  logic [15:0] sum;
  logic [15:0] word;
  logic [16:0] rawSum;
  logic [15:0] foldSum;

  assign word      = {hiByte, inData};
  assign rawSum    = {1'b0, sum} + {1'b0, word};
  assign foldSum   = rawSum[15:0] + {15'd0, rawSum[16]};
  assign wordAllOnes = (foldSum == 16'hFFFF);
  assign etherType = {typeHi, inData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      typeHi    <= 8'd0;
      hiByte    <= 8'd0;
      hiPending <= 1'b0;
      sum       <= 16'd0;
    end else begin
      if (strobe.latchType) typeHi <= inData;
      if (strobe.clrSum) begin
        sum       <= 16'd0;
        hiPending <= 1'b0;
      end else if (strobe.latchHi) begin
        hiByte    <= inData;
        hiPending <= 1'b1;
      end else if (strobe.addWord) begin
        sum       <= foldSum;
        hiPending <= 1'b0;
      end
    end
  end

  AST_WORD_HAS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.addWord |-> hiPending); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.latchHi && strobe.addWord)); // R4

endmodule

// File: rtl/ipcsum_ctrl.sv
module ipcsum_ctrl
  import ipcsum_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int TYPE_OFF = 12,
  parameter bit VLAN_EN  = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inSof,
  input  logic        inEof,
  input  logic [15:0] etherType,
  input  logic        wordAllOnes,
  output dpStrobe_t   strobe,
  output logic        outValid,
  output logic        isIpv4,
  output logic        isIpv6,
  output logic        hdrErr
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] OFF_BASE = CNT_W'(TYPE_OFF);
  localparam logic [CNT_W-1:0] OFF_STEP = CNT_W'(VLAN_LEN);

  logic                 inFrame;
  logic [CNT_W-1:0]     byteCnt;
  logic [CNT_W-1:0]     typeOff;
  logic                 vlanSeen;
  frameKind_t           kind;
  logic                 hdrActive;
  logic [HDR_POS_W-1:0] hdrPos;
  logic [HDR_POS_W-1:0] hdrLen;
  logic                 hdrDone;
  logic                 sumOk;
  logic                 badHdr;
  logic                 enLat;

  logic                 take;
  logic [CNT_W-1:0]     idx;
  logic [CNT_W-1:0]     curTypeOff;
  logic                 curVlan;
  frameKind_t           curKind;
  logic                 curHdrActive;
  logic [HDR_POS_W-1:0] curHdrPos;
  logic [HDR_POS_W-1:0] curHdrLen;
  logic                 curHdrDone;
  logic                 curSumOk;
  logic                 curBad;
  logic                 curEn;

  logic                 atTypeHi;
  logic                 atTypeLo;
  logic                 vlanHit;
  frameKind_t           decidedKind;
  frameKind_t           kindNext;
  logic                 hdrByte;
  logic                 isFirst;
  logic                 firstBad;
  logic [HDR_POS_W-1:0] lenNow;
  logic                 isLast;
  logic                 doneFinal;
  logic                 okFinal;
  logic                 badFinal;
  logic                 startHdr;

  assign take         = inValid && (inSof || inFrame);
  assign idx          = inSof ? '0 : byteCnt;
  assign curTypeOff   = inSof ? OFF_BASE : typeOff;
  assign curVlan      = inSof ? 1'b0 : vlanSeen;
  assign curKind      = inSof ? KIND_NONE : kind;
  assign curHdrActive = inSof ? 1'b0 : hdrActive;
  assign curHdrPos    = inSof ? '0 : hdrPos;
  assign curHdrLen    = inSof ? '0 : hdrLen;
  assign curHdrDone   = inSof ? 1'b0 : hdrDone;
  assign curSumOk     = inSof ? 1'b0 : sumOk;
  assign curBad       = inSof ? 1'b0 : badHdr;
  assign curEn        = inSof ? enable : enLat;

  assign atTypeHi = take && (curKind == KIND_NONE) && (idx == curTypeOff);
  assign atTypeLo = take && (curKind == KIND_NONE) && (idx == curTypeOff + 1'b1);

  generate
    if (VLAN_EN) begin : g_vlan
      assign vlanHit = (etherType == TYPE_VLAN) && !curVlan;
    end else begin : g_noVlan
      assign vlanHit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (etherType == TYPE_IPV4)      decidedKind = KIND_V4;
    else if (etherType == TYPE_IPV6) decidedKind = KIND_V6;
    else                             decidedKind = KIND_OTHER;
  end

  assign kindNext = (atTypeLo && !vlanHit) ? decidedKind : curKind;
  assign startHdr = atTypeLo && !vlanHit && (decidedKind == KIND_V4);

  assign hdrByte  = take && curHdrActive;
  assign isFirst  = hdrByte && (curHdrPos == '0);
  assign firstBad = isFirst && ((inData[7:4] != 4'd4) || (inData[3:0] < 4'(MIN_IHL)));
  assign lenNow   = isFirst ? {inData[3:0], 2'b00} : curHdrLen;
  assign isLast   = hdrByte && !firstBad && (curHdrPos == lenNow - 1'b1);

  assign doneFinal = curHdrDone || isLast;
  assign okFinal   = isLast ? wordAllOnes : curSumOk;
  assign badFinal  = curBad || firstBad;

  always_comb begin
    strobe           = '0;
    strobe.clrSum    = take && inSof;
    strobe.latchType = atTypeHi;
    strobe.latchHi   = hdrByte && !curHdrPos[0] && !firstBad;
    strobe.addWord   = hdrByte && curHdrPos[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame   <= 1'b0;
      byteCnt   <= '0;
      typeOff   <= OFF_BASE;
      vlanSeen  <= 1'b0;
      kind      <= KIND_NONE;
      hdrActive <= 1'b0;
      hdrPos    <= '0;
      hdrLen    <= '0;
      hdrDone   <= 1'b0;
      sumOk     <= 1'b0;
      badHdr    <= 1'b0;
      enLat     <= 1'b0;
      outValid  <= 1'b0;
      isIpv4    <= 1'b0;
      isIpv6    <= 1'b0;
      hdrErr    <= 1'b0;
    end else begin
      outValid <= 1'b0;
      isIpv4   <= 1'b0;
      isIpv6   <= 1'b0;
      hdrErr   <= 1'b0;
      if (take) begin
        inFrame   <= !inEof;
        byteCnt   <= (idx == CNT_MAX) ? idx : idx + 1'b1;
        enLat     <= curEn;
        kind      <= kindNext;
        typeOff   <= (atTypeLo && vlanHit) ? curTypeOff + OFF_STEP : curTypeOff;
        vlanSeen  <= curVlan || (atTypeLo && vlanHit);
        hdrDone   <= doneFinal;
        sumOk     <= okFinal;
        badHdr    <= badFinal;
        if (startHdr) begin
          hdrActive <= 1'b1;
          hdrPos    <= '0;
          hdrLen    <= '0;
        end else if (hdrByte) begin
          hdrActive <= !(firstBad || isLast);
          hdrPos    <= curHdrPos + 1'b1;
          hdrLen    <= lenNow;
        end else begin
          hdrActive <= curHdrActive;
          hdrPos    <= curHdrPos;
          hdrLen    <= curHdrLen;
        end
        if (inEof) begin
          outValid <= 1'b1;
          isIpv4   <= curEn && (kindNext == KIND_V4);
          isIpv6   <= curEn && (kindNext == KIND_V6);
          hdrErr   <= curEn && (kindNext == KIND_V4) &&
                      (badFinal || !doneFinal || !okFinal);
        end
      end
    end
  end

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(isIpv4 || isIpv6 || hdrErr)); // R1

  AST_TYPE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(isIpv4 && isIpv6)); // R2

  AST_VLAN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    vlanSeen |-> (typeOff == OFF_BASE + OFF_STEP)); // R3

  AST_HDR_MIN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    hdrDone |-> (hdrLen >= HDR_POS_W'(MIN_IHL * 4))); // R6

  AST_ERR_NEEDS_V4: assert property (@(posedge clk) disable iff (!rstN)
    hdrErr |-> isIpv4); // R10

  AST_HDR_ONLY_V4: assert property (@(posedge clk) disable iff (!rstN)
    hdrActive |-> (kind == KIND_V4)); // R5

endmodule

// File: rtl/ipcsum_checker.sv
module ipcsum_checker
  import ipcsum_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int TYPE_OFF = 12,
  parameter bit VLAN_EN  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       inSof,
  input  logic       inEof,
  output logic       outValid,
  output logic       isIpv4,
  output logic       isIpv6,
  output logic       hdrErr
);

  dpStrobe_t   strobe;
  logic [15:0] etherType;
  logic        wordAllOnes;

  ipcsum_ctrl #(
    .CNT_W   (CNT_W),
    .TYPE_OFF(TYPE_OFF),
    .VLAN_EN (VLAN_EN)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .inValid    (inValid),
    .inData     (inData),
    .inSof      (inSof),
    .inEof      (inEof),
    .etherType  (etherType),
    .wordAllOnes(wordAllOnes),
    .strobe     (strobe),
    .outValid   (outValid),
    .isIpv4     (isIpv4),
    .isIpv6     (isIpv6),
    .hdrErr     (hdrErr)
  );

  ipcsum_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inData     (inData),
    .etherType  (etherType),
    .wordAllOnes(wordAllOnes)
  );

endmodule

// File: tb/ipcsum_checker_tb.sv
module ipcsum_checker_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'd0;
  logic       inSof = 1'b0;
  logic       inEof = 1'b0;
  logic       outValid, isIpv4, isIpv6, hdrErr;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] fb [0:127];
  int fl;
  int hdrBase;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipcsum_checker u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .inValid(inValid),
    .inData(inData), .inSof(inSof), .inEof(inEof),
    .outValid(outValid), .isIpv4(isIpv4), .isIpv6(isIpv6), .hdrErr(hdrErr)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: {valid,v4,v6,err} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Frame image: MACs, optional tags, type, IPv4-shaped header, payload.
  task automatic build(input int nTags, input logic [15:0] etype, input logic [3:0] ver,
                       input logic [3:0] ihl, input bit corrupt, input int payload);
    int p;
    int hl;
    int s;
    p = 0;
    for (int i = 0; i < 12; i++) begin fb[p] = 8'(8'h10 + i); p++; end
    for (int t = 0; t < nTags; t++) begin
      fb[p] = 8'h81; fb[p+1] = 8'h00; fb[p+2] = 8'h00; fb[p+3] = 8'h05; p += 4;
    end
    fb[p] = etype[15:8]; fb[p+1] = etype[7:0]; p += 2;
    hdrBase = p;
    hl = (ihl < 5) ? 20 : int'(ihl) * 4;
    for (int i = 0; i < hl; i++) fb[p+i] = 8'((i * 37 + 11) & 8'hFF);
    fb[p] = {ver, ihl};
    fb[p+10] = 8'h00; fb[p+11] = 8'h00;
    s = 0;
    for (int j = 0; j < hl/2; j++) begin
      s = s + {fb[p+2*j], fb[p+2*j+1]};
      s = (s & 16'hFFFF) + (s >> 16);
    end
    s = (~s) & 16'hFFFF;
    if (corrupt) s = s ^ 16'h0100;
    fb[p+10] = s[15:8]; fb[p+11] = s[7:0];
    p += hl;
    for (int i = 0; i < payload; i++) begin fb[p] = 8'(8'hA5 ^ i); p++; end
    fl = p;
  endtask

  task automatic send(input int n, input bit gaps, input bit enSof, input bit enRest);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin
        inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
        @(negedge clk);
      end
      inValid = 1'b1; inData = fb[i]; inSof = (i == 0); inEof = (i == n - 1);
      enable = (i == 0) ? enSof : enRest;
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; enable = 1'b1;
  endtask

  task automatic expectRes(input string req, input bit v4, input bit v6, input bit err);
    chk(req, {outValid, isIpv4, isIpv6, hdrErr}, {1'b1, v4, v6, err});
  endtask

  task automatic tReset;
    chk("R1 reset", {outValid, isIpv4, isIpv6, hdrErr}, 4'b0000);
  endtask

  task automatic tIpv4Good;
    build(0, 16'h0800, 4'd4, 4'd5, 1'b0, 8);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R2 R4 ipv4 valid", 1, 0, 0);
    @(negedge clk);
    chk("R1 strobe one cycle", {outValid, isIpv4, isIpv6, hdrErr}, 4'b0000);
  endtask

  task automatic tIpv4BadSum;
    build(0, 16'h0800, 4'd4, 4'd5, 1'b1, 4);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R4 bad checksum", 1, 0, 1);
  endtask

  task automatic tOtherTypes;
    build(0, 16'h86DD, 4'd6, 4'd0, 1'b0, 30);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R2 ipv6", 0, 1, 0);
    build(0, 16'h0806, 4'd4, 4'd5, 1'b1, 4);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R2 R10 other type no error", 0, 0, 0);
  endtask

  task automatic tVlan;
    build(1, 16'h0800, 4'd4, 4'd5, 1'b0, 2);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R3 tagged ipv4", 1, 0, 0);
    build(1, 16'h0800, 4'd4, 4'd5, 1'b1, 2);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R3 tagged ipv4 bad sum", 1, 0, 1);
    build(1, 16'h86DD, 4'd6, 4'd5, 1'b0, 2);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R3 tagged ipv6", 0, 1, 0);
    build(2, 16'h0800, 4'd4, 4'd5, 1'b0, 2);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R3 second tag not skipped", 0, 0, 0);
  endtask

  task automatic tOptions;
    build(0, 16'h0800, 4'd4, 4'd7, 1'b0, 12);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R5 header with options", 1, 0, 0);
    build(0, 16'h0800, 4'd4, 4'd5, 1'b0, 12);
    fb[hdrBase + 20] = 8'hFF; fb[hdrBase + 21] = 8'h00;
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R5 bytes past header ignored", 1, 0, 0);
  endtask

  task automatic tBadFields;
    build(0, 16'h0800, 4'd4, 4'd4, 1'b0, 4);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R6 ihl below five", 1, 0, 1);
    build(0, 16'h0800, 4'd6, 4'd5, 1'b0, 4);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R7 wrong version", 1, 0, 1);
  endtask

  task automatic tTruncate;
    build(0, 16'h0800, 4'd4, 4'd5, 1'b0, 0);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R8 ends on last header byte", 1, 0, 0);
    send(fl - 1, 1'b0, 1'b1, 1'b1);
    expectRes("R8 one byte short", 1, 0, 1);
    send(14, 1'b0, 1'b1, 1'b1);
    expectRes("R8 ends after type", 1, 0, 1);
  endtask

  task automatic tEnable;
    build(0, 16'h0800, 4'd4, 4'd5, 1'b1, 4);
    send(fl, 1'b0, 1'b0, 1'b0);
    expectRes("R9 disabled", 0, 0, 0);
    send(fl, 1'b0, 1'b1, 1'b0);
    expectRes("R9 enable sampled at start", 1, 0, 1);
    send(fl, 1'b0, 1'b0, 1'b1);
    expectRes("R9 late enable ignored", 0, 0, 0);
  endtask

  task automatic tStream;
    build(1, 16'h0800, 4'd4, 4'd6, 1'b0, 5);
    send(fl, 1'b1, 1'b1, 1'b1);
    expectRes("R11 idle gaps", 1, 0, 0);
    build(0, 16'h0800, 4'd4, 4'd5, 1'b1, 0);
    send(24, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      inValid = 1'b1; inData = 8'h45; inEof = (i == 9);
      @(negedge clk);
    end
    inValid = 1'b0; inEof = 1'b0;
    chk("R11 bytes outside frame", {outValid, isIpv4, isIpv6, hdrErr}, 4'b0000);
    for (int i = 0; i < 20; i++) begin
      inValid = 1'b1; inData = fb[i]; inSof = (i == 0); inEof = 1'b0;
      @(negedge clk);
    end
    inValid = 1'b0; inSof = 1'b0;
    build(0, 16'h86DD, 4'd6, 4'd5, 1'b0, 3);
    send(fl, 1'b0, 1'b1, 1'b1);
    expectRes("R11 restart mid-frame", 0, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tIpv4Good();
    tIpv4BadSum();
    tOtherTypes();
    tVlan();
    tOptions();
    tBadFields();
    tTruncate();
    tEnable();
    tStream();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule